// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer

This block drives the command bus of an SDRAM device through its initialization sequence. Software starts it by writing a trigger bit. The block then issues one Precharge All command, one Load Mode Register command and a burst of Auto-Refresh commands. Each command appears on a two-bit command output together with a one-cycle strobe. The gap between commands comes from programmable timing fields. An order bit selects whether the mode-register load comes before or after the refresh burst. A busy flag covers the whole run, and a one-cycle done pulse marks its end.

The controller comes out of reset enabled, with default timing values in force. The timing fields and the order bit can only be changed while the controller is disabled. Writes made while it is enabled have no effect. The intended flow is: disable, program, enable, start. The block keeps checking that the row-active time plus the row-precharge time covers the longest of the row-cycle, refresh-cycle and self-refresh-exit times. If it does not, a configuration error is raised and start requests are refused.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, busy, done, cmd_stb and cfg_err are 0, cmd is NOP (2'b00), the controller is enabled, the order bit is 1 and the timing defaults are tRP=2, tRAS=5, tRC=7, tRFC=6, tXSR=7.
- R2: A write to address 0 with bit 1 set is a start request. It is accepted when the controller is enabled, idle and free of configuration error. A Precharge All (cmd 2'b01) strobe then appears in the cycle after the write edge. From that strobe until the done cycle, busy is 1.
- R3: With the order bit (address 0, bit 2) at 1, the commands are Precharge All, then Load Mode Register (2'b10), then eight Auto-Refresh (2'b11).
- R4: With the order bit at 0, the commands are Precharge All, then eight Auto-Refresh, then Load Mode Register.
- R5: Each run issues exactly ten strobes, of which exactly eight are Auto-Refresh.
- R6: The next strobe or done comes tRP cycles after Precharge All, tRFC cycles after each Auto-Refresh and 2 cycles after Load Mode Register.
- R7: done is a one-cycle pulse. It comes when the wait after the last command expires, and busy is 0 in that cycle.
- R8: cfg_err is 1 exactly when tRAS + tRP < max(tRC, tRFC, tXSR). The fields are 4 bits: address 1 holds tRP[3:0], tRAS[7:4] and tRC[11:8]; address 2 holds tRFC[3:0] and tXSR[7:4].
- R9: Writes to address 1 or 2 have no effect while the controller is enabled (address 0, bit 0).
- R10: A write to the order bit has no effect while the controller is enabled. The enable bit itself is always writable.
- R11: A start request is ignored while busy, while the controller is disabled, or while cfg_err is 1.
- R12: A programmed tRP or tRFC of 0 acts as a one-cycle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 timing A, 2 timing B |
| wr_data | input | 16 | Register write data |
| cmd | output | 2 | SDRAM command: 00 NOP, 01 Precharge All, 10 Load Mode, 11 Auto-Refresh |
| cmd_stb | output | 1 | One-cycle strobe marking a valid command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| cfg_err | output | 1 | Timing relation violated |

## Verification
A step counter that is wrong shows up at once as a wrong command code on the next strobe. A loss of step count shows up as a strobe total other than ten, or as a missing done, at the end of the run. A wait counter that is off by one moves every later strobe, so it shows in the first gap after the faulty load. A broken write lock only shows in later runs: the gap changes, the command order flips, or cfg_err moves. For this reason every lock test is followed by a run that is timed in full.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [1:0] {
    CMD_NOP       = 2'b00,
    CMD_PRE_ALL   = 2'b01,
    CMD_LOAD_MODE = 2'b10,
    CMD_AUTO_REF  = 2'b11
  } sdram_cmd_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_TIM_A = 2'd1;
  localparam logic [1:0] ADDR_TIM_B = 2'd2;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_GO_BIT    = 1;
  localparam int CTRL_ORDER_BIT = 2;

  localparam int LMR_GAP = 2;
endpackage

// File: rtl/sdram_init_regs.sv
module sdram_init_regs
  import sdram_init_pkg::*;
#(
  parameter int TW        = 4,
  parameter int DW        = 16,
  parameter int RST_TRP   = 2,
  parameter int RST_TRAS  = 5,
  parameter int RST_TRC   = 7,
  parameter int RST_TRFC  = 6,
  parameter int RST_TXSR  = 7,
  parameter bit RST_ORDER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          en,
  output logic          order,
  output logic [TW-1:0] trp,
  output logic [TW-1:0] trfc,
  output logic          cfg_err,
  output logic          start_req
);
  logic          en_q, en_d, order_q, order_d;
  logic [TW-1:0] trp_q, trp_d, tras_q, tras_d, trc_q, trc_d;
  logic [TW-1:0] trfc_q, trfc_d, txsr_q, txsr_d;
  logic [TW:0]   sum_w, max_w;
  logic          unused_wdata;

  assign unused_wdata = ^wr_data[DW-1:3*TW];

  always_comb begin
    en_d    = en_q;
    order_d = order_q;
    trp_d   = trp_q;
    tras_d  = tras_q;
    trc_d   = trc_q;
    trfc_d  = trfc_q;
    txsr_d  = txsr_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          en_d = wr_data[CTRL_EN_BIT];
          if (!en_q) order_d = wr_data[CTRL_ORDER_BIT];
        end
        ADDR_TIM_A: if (!en_q) begin
          trp_d  = wr_data[0*TW +: TW];
          tras_d = wr_data[1*TW +: TW];
          trc_d  = wr_data[2*TW +: TW];
        end
        ADDR_TIM_B: if (!en_q) begin
          trfc_d = wr_data[0*TW +: TW];
          txsr_d = wr_data[1*TW +: TW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      order_q <= RST_ORDER;
      trp_q   <= TW'(RST_TRP);
      tras_q  <= TW'(RST_TRAS);
      trc_q   <= TW'(RST_TRC);
      trfc_q  <= TW'(RST_TRFC);
      txsr_q  <= TW'(RST_TXSR);
    end else begin
      en_q    <= en_d;
      order_q <= order_d;
      trp_q   <= trp_d;
      tras_q  <= tras_d;
      trc_q   <= trc_d;
      trfc_q  <= trfc_d;
      txsr_q  <= txsr_d;
    end
  end

  always_comb begin
    sum_w = {1'b0, tras_q} + {1'b0, trp_q};
    max_w = {1'b0, trc_q};
    if ({1'b0, trfc_q} > max_w) max_w = {1'b0, trfc_q};
    if ({1'b0, txsr_q} > max_w) max_w = {1'b0, txsr_q};
  end

  assign cfg_err   = sum_w < max_w;
  assign start_req = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_GO_BIT];
  assign en        = en_q;
  assign order     = order_q;
  assign trp       = trp_q;
  assign trfc      = trfc_q;

  // R9: timing fields hold while the controller is enabled
  a_r9_timing_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(trp_q) && $stable(tras_q) && $stable(trc_q)
              && $stable(trfc_q) && $stable(txsr_q)));
  // R10: order bit holds while enabled
  a_r10_order_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(order_q));
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == TW'(1));

  // R6: an unloaded, running count steps down by one per cycle
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q > TW'(1)) |=> (cnt_q == $past(cnt_q) - TW'(1)));
  // R12: a load never leaves the counter idle
  a_r12_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int TW   = 4,
  parameter int NREF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          en,
  input  logic          cfg_err,
  input  logic          order,
  input  logic [TW-1:0] trp,
  input  logic [TW-1:0] trfc,
  input  logic          expire,
  output logic          load,
  output logic [TW-1:0] load_val,
  output sdram_cmd_e    cmd,
  output logic          cmd_stb,
  output logic          busy,
  output logic          done
);
  localparam int NSTEP = NREF + 2;
  localparam int SW    = $clog2(NSTEP);
  localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

  logic          busy_q, busy_d, stb_q, stb_d, done_q, done_d;
  logic [SW-1:0] step_q, step_d;
  sdram_cmd_e    cmd_q, cmd_d;
  logic          go;

  function automatic sdram_cmd_e cmd_for(input logic [SW-1:0] s, input logic ord);
    if (s == '0)             return CMD_PRE_ALL;
    else if (ord)            return (s == SW'(1)) ? CMD_LOAD_MODE : CMD_AUTO_REF;
    else                     return (s == LAST)   ? CMD_LOAD_MODE : CMD_AUTO_REF;
  endfunction

  function automatic logic [TW-1:0] gap_for(input sdram_cmd_e c,
                                            input logic [TW-1:0] rp,
                                            input logic [TW-1:0] rfc);
    case (c)
      CMD_PRE_ALL:  return (rp  == '0) ? TW'(1) : rp;
      CMD_AUTO_REF: return (rfc == '0) ? TW'(1) : rfc;
      default:      return TW'(LMR_GAP);
    endcase
  endfunction

  assign go = start_req && en && !cfg_err && !busy_q;

  always_comb begin
    busy_d   = busy_q;
    step_d   = step_q;
    cmd_d    = CMD_NOP;
    stb_d    = 1'b0;
    done_d   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    if (!busy_q) begin
      if (go) begin
        busy_d   = 1'b1;
        step_d   = '0;
        cmd_d    = CMD_PRE_ALL;
        stb_d    = 1'b1;
        load     = 1'b1;
        load_val = gap_for(CMD_PRE_ALL, trp, trfc);
      end
    end else if (expire) begin
      if (step_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        step_d   = step_q + SW'(1);
        cmd_d    = cmd_for(step_d, order);
        stb_d    = 1'b1;
        load     = 1'b1;
        load_val = gap_for(cmd_d, trp, trfc);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      cmd_q  <= CMD_NOP;
      stb_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      cmd_q  <= cmd_d;
      stb_q  <= stb_d;
      done_q <= done_d;
    end
  end

  assign cmd     = cmd_q;
  assign cmd_stb = stb_q;
  assign busy    = busy_q;
  assign done    = done_q;

  // R2: every run opens with Precharge All
  a_r2_first_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (stb_q && cmd_q == CMD_PRE_ALL));
  // R6: strobes only carry real commands and only inside a run
  a_r6_stb_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (busy_q && cmd_q != CMD_NOP));
  // R7: done is single-cycle and never overlaps busy
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11: a run only begins from idle
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || step_q >= $past(step_q)));
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int TW   = 4,
  parameter int DW   = 16,
  parameter int NREF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [1:0]    cmd,
  output logic          cmd_stb,
  output logic          busy,
  output logic          done,
  output logic          cfg_err
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_int;
  logic          en_w, order_w, start_w, load_w, expire_w;
  logic [TW-1:0] trp_w, trfc_w, load_val_w;
  sdram_cmd_e    cmd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sdram_init_regs #(.TW(TW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en(en_w), .order(order_w), .trp(trp_w),
    .trfc(trfc_w), .cfg_err(cfg_err), .start_req(start_w)
  );

  sdram_init_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n_int), .load(load_w), .load_val(load_val_w),
    .expire(expire_w)
  );

  sdram_init_fsm #(.TW(TW), .NREF(NREF)) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .start_req(start_w), .en(en_w),
    .cfg_err(cfg_err), .order(order_w), .trp(trp_w), .trfc(trfc_w),
    .expire(expire_w), .load(load_w), .load_val(load_val_w),
    .cmd(cmd_w), .cmd_stb(cmd_stb), .busy(busy), .done(done)
  );

  assign cmd = cmd_w;
endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  cmd;
  logic        cmd_stb, busy, done, cfg_err;
  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #10 clk = ~clk;

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd(cmd), .cmd_stb(cmd_stb), .busy(busy),
    .done(done), .cfg_err(cfg_err)
  );

  // vector: {exp_err, order, trp, tras, trc, trfc, txsr}
  localparam logic [21:0] VEC [5] = '{
    {1'b0, 1'b0, 4'd3, 4'd4, 4'd7, 4'd5, 4'd6},
    {1'b0, 1'b1, 4'd1, 4'd9, 4'd8, 4'd2, 4'd9},
    {1'b1, 1'b1, 4'd2, 4'd3, 4'd6, 4'd4, 4'd4},
    {1'b0, 1'b0, 4'd0, 4'd8, 4'd5, 4'd0, 4'd3},
    {1'b1, 1'b0, 4'd4, 4'd4, 4'd3, 4'd2, 4'd9}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'd0;
  endtask

  function automatic int exp_cmd(input bit ord, input int k);
    if (k == 0) return 1;
    if (ord) return (k == 1) ? 2 : 3;
    return (k == 9) ? 2 : 3;
  endfunction

  function automatic int gap(input int c, input int rp, input int rfc);
    if (c == 1) return (rp == 0) ? 1 : rp;
    if (c == 3) return (rfc == 0) ? 1 : rfc;
    return 2;
  endfunction

  // called right after the start write; samples at falling edges
  task automatic run_expect(input bit ord, input int rp, input int rfc,
                            input int inject, input string req);
    int k = 0, nref = 0, exp_t = 0;
    bit seen_done = 1'b0, busy_bad = 1'b0;
    for (int t = 0; t < 400 && !seen_done; t++) begin
      if (cmd_stb) begin
        int ec;
        ec = exp_cmd(ord, k);
        chk(int'(cmd) == ec, req, "command code", int'(cmd), ec);
        chk(t == exp_t, "R6", "strobe cycle", t, exp_t);
        if (cmd == 2'b11) nref++;
        exp_t = exp_t + gap(ec, rp, rfc);
        k++;
      end
      if (done) begin
        seen_done = 1'b1;
        chk(t == exp_t, "R7", "done cycle", t, exp_t);
        chk(!busy, "R7", "busy at done", int'(busy), 0);
      end else if (!busy) busy_bad = 1'b1;
      if (t == inject) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = {13'd0, ord, 1'b1, 1'b1};
      end else if (t == inject + 1) begin
        wr_en = 1'b0; wr_data = 16'd0;
      end
      @(negedge clk);
    end
    chk(seen_done, "R7", "done seen", int'(seen_done), 1);
    chk(!busy_bad, "R2", "busy held through run", int'(busy_bad), 0);
    chk(k == 10, "R5", "strobe total", k, 10);
    chk(nref == 8, "R5", "auto-refresh total", nref, 8);
    chk(!done, "R7", "done after pulse", int'(done), 0);
  endtask

  task automatic expect_quiet(input string req, input string what);
    int hits = 0;
    for (int t = 0; t < 20; t++) begin
      if (cmd_stb || busy) hits++;
      @(negedge clk);
    end
    chk(hits == 0, req, what, hits, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++; nchk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy", int'(busy), 0);
    chk(!done, "R1", "done", int'(done), 0);
    chk(!cmd_stb, "R1", "cmd_stb", int'(cmd_stb), 0);
    chk(cmd == 2'b00, "R1", "cmd", int'(cmd), 0);
    chk(!cfg_err, "R1", "cfg_err", int'(cfg_err), 0);

    // R1/R2/R3: enabled by default, default order 1; R11 start mid-run ignored
    wr(2'd0, 16'h0003);
    run_expect(1'b1, 2, 6, 5, "R3");

    // R9: timing writes while enabled do nothing (would raise cfg_err)
    wr(2'd1, {4'd0, 4'd15, 4'd1, 4'd1});
    chk(!cfg_err, "R9", "cfg_err after locked write", int'(cfg_err), 0);
    // R10: order write while enabled does nothing
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0003);
    run_expect(1'b1, 2, 6, -1, "R10");

    // R11: start while disabled
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0002);
    expect_quiet("R11", "activity when disabled");

    // table walk: R4 R8 R11 R12
    for (int i = 0; i < 5; i++) begin
      logic [21:0] v;
      v = VEC[i];
      wr(2'd0, 16'h0000);
      wr(2'd1, {4'd0, v[11:8], v[15:12], v[19:16]});
      wr(2'd2, {8'd0, v[3:0], v[7:4]});
      wr(2'd0, {13'd0, v[20], 2'b00});
      chk(cfg_err == v[21], "R8", "cfg_err", int'(cfg_err), int'(v[21]));
      wr(2'd0, {13'd0, v[20], 2'b01});
      wr(2'd0, {13'd0, v[20], 2'b11});
      if (v[21]) expect_quiet("R11", "activity with cfg_err");
      else run_expect(v[20], int'(v[19:16]), int'(v[7:4]), -1,
                      v[20] ? "R3" : (v[19:16] == 0 ? "R12" : "R4"));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule